// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block listens to the clock and data lines of a two-wire serial bus without ever driving them. Both lines are brought into the fast system clock domain through a two-stage synchroniser, then cleaned by a three-sample majority vote so that a single-cycle spike cannot be mistaken for a real transition. The cleaned lines are classified into bus events: a fresh start, a repeated start, a committed data bit, the acknowledge slot of each byte, a stretched (waiting) clock, and a stop.

Every event leaves the block as a one-cycle strobe. A busy flag tracks ownership of the bus from start to stop, a byte register with a valid strobe presents each assembled byte, and a pair of strobes reports whether the ninth bit was an acknowledge or a refusal. A separate error strobe marks a data-line transition during a high clock phase that falls inside a byte rather than on a byte boundary. Addressing, bus driving and software access belong to other blocks.

Top module: `twb_cond_mon`

## Requirements
- R1: After reset is released, `busy_o` and `wait_o` are low and no strobe output pulses while both lines stay high.
- R2: A falling data line while the clock line is high, with `busy_o` low, pulses `start_o` once and sets `busy_o`.
- R3: A falling data line while the clock line is high, with `busy_o` already high, pulses `rstart_o` instead of `start_o`, and `busy_o` stays high.
- R4: A rising data line while the clock line is high pulses `stop_o` once and clears `busy_o`.
- R5: While busy, each bit is the data level held through a clock-high phase and is committed on the clock's falling edge with a `bit_o` pulse; bits fill the byte MSB first, and after the eighth data bit `byte_vld_o` pulses once with the byte on `byte_o`, which holds it until the next byte.
- R6: The bit after each eighth data bit is the acknowledge slot: data low pulses `ack_o`, data high pulses `nack_o`, never both; the bit count then restarts so the next byte is assembled afresh.
- R7: When the filtered clock line stays low for more than `WAIT_CYC` system clocks, `wait_o` rises and stays high until the clock line rises; clock-low phases of normal length leave `wait_o` low.
- R8: A start, repeated start or stop seen after one to eight bits of the current byte have been committed still pulses its own strobe and also pulses `err_o` in the same cycle; at a byte boundary (no bits committed, or just after the acknowledge slot) `err_o` stays low.
- R9: A pulse lasting a single system clock on either line has no effect: no strobe fires and `busy_o` does not change.
- R10: `start_o`, `rstart_o` and `stop_o` are single-cycle pulses and at most one of them is high in any cycle.
- R11: Clock pulses while the bus is not busy commit no bits (`bit_o` stays low), and data-line changes while the clock line is low raise no condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| start_o | output | 1 | Strobe: start seen on an idle bus |
| rstart_o | output | 1 | Strobe: repeated start seen on a busy bus |
| stop_o | output | 1 | Strobe: stop seen |
| bit_o | output | 1 | Strobe: one bit committed (data or acknowledge slot) |
| bit_val_o | output | 1 | Value of the bit committed with `bit_o` |
| byte_o | output | 8 | Most recently assembled byte |
| byte_vld_o | output | 1 | Strobe: `byte_o` was just updated |
| ack_o | output | 1 | Strobe: acknowledge slot read low |
| nack_o | output | 1 | Strobe: acknowledge slot read high |
| busy_o | output | 1 | High from start to stop |
| wait_o | output | 1 | High while a stretched clock-low phase lasts |
| err_o | output | 1 | Strobe: condition seen inside a byte |

## Verification
The interesting overlap is a stop or start condition that lands inside a byte: the condition strobe and the error strobe must then fire in the same cycle. The bench provokes this by aborting a byte after three bits with a stop, and judges it by counting both strobes over the scenario and confirming that `busy_o` dropped; the checker relates the two strobes cycle by cycle. The opposite case, a stop or repeated start right after an acknowledge slot, is judged by the error count staying at zero.

// File: rtl/twb_mon_pkg.sv
package twb_mon_pkg;

  localparam int unsigned TWB_BYTE_BITS = 8;

  // Condition strobes produced together by the tracker
  typedef struct packed {
    logic start;
    logic rstart;
    logic stop;
    logic err;
  } twb_cond_t;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

endpackage

// File: rtl/twb_line_filter.sv
module twb_line_filter #(
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  import twb_mon_pkg::*;

  logic [1:0] sync_q;
  logic [2:0] hist_q;
  logic       filt_q;
  logic       filt_d;

  always_comb begin
    filt_d = maj3(hist_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{RST_VAL}};
      hist_q <= {3{RST_VAL}};
      filt_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], line_i};
      hist_q <= {hist_q[1:0], sync_q[1]};
      filt_q <= filt_d;
    end
  end

  assign line_o = filt_q;

endmodule

// File: rtl/twb_stretch_timer.sv
module twb_stretch_timer #(
  parameter int unsigned WAIT_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  output logic wait_o
);
  localparam int unsigned CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (scl_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LIMIT) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign wait_o = !scl_i && (cnt_q == LIMIT);

endmodule

// File: rtl/twb_cond_tracker.sv
module twb_cond_tracker #(
  parameter int unsigned BYTE_BITS = twb_mon_pkg::TWB_BYTE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output twb_mon_pkg::twb_cond_t cond_o,
  output logic                 bit_o,
  output logic                 bit_val_o,
  output logic [BYTE_BITS-1:0] byte_o,
  output logic                 byte_vld_o,
  output logic                 ack_o,
  output logic                 nack_o,
  output logic                 busy_o
);
  import twb_mon_pkg::*;

  localparam int unsigned CW = $clog2(BYTE_BITS + 1);
  localparam logic [CW-1:0] ACK_SLOT = CW'(BYTE_BITS);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_BITS - 1);

  logic scl_q, sda_q;
  logic busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BYTE_BITS-1:0] shift_q, shift_d, byte_q, byte_d;
  logic pend_val_q, pend_val_d, pend_ok_q, pend_ok_d;
  twb_cond_t cond_q, cond_d;
  logic bit_q, bit_d, bitv_q, bitv_d;
  logic bvld_q, bvld_d, ack_q, ack_d, nack_q, nack_d;

  logic scl_rise, scl_fall, scl_hold, sda_fall, sda_rise;
  logic cond_fall, cond_rise, commit;

  always_comb begin
    scl_rise  = scl_i & ~scl_q;
    scl_fall  = ~scl_i & scl_q;
    scl_hold  = scl_i & scl_q;
    sda_fall  = ~sda_i & sda_q;
    sda_rise  = sda_i & ~sda_q;
    cond_fall = scl_hold & sda_fall;
    cond_rise = scl_hold & sda_rise;
    commit    = scl_fall & pend_ok_q & busy_q;

    cond_d.start  = cond_fall & ~busy_q;
    cond_d.rstart = cond_fall & busy_q;
    cond_d.stop   = cond_rise;
    cond_d.err    = (cond_fall | cond_rise) & (cnt_q != '0);

    busy_d     = busy_q;
    cnt_d      = cnt_q;
    shift_d    = shift_q;
    byte_d     = byte_q;
    pend_val_d = pend_val_q;
    pend_ok_d  = pend_ok_q;
    bit_d      = commit;
    bitv_d     = pend_val_q;
    bvld_d     = 1'b0;
    ack_d      = 1'b0;
    nack_d     = 1'b0;

    if (scl_rise) begin
      pend_val_d = sda_i;
      pend_ok_d  = busy_q;
    end

    if (commit) begin
      if (cnt_q == ACK_SLOT) begin
        ack_d  = ~pend_val_q;
        nack_d = pend_val_q;
        cnt_d  = '0;
      end else begin
        shift_d = {shift_q[BYTE_BITS-2:0], pend_val_q};
        cnt_d   = cnt_q + 1'b1;
        if (cnt_q == LAST_BIT) begin
          bvld_d = 1'b1;
          byte_d = {shift_q[BYTE_BITS-2:0], pend_val_q};
        end
      end
    end

    if (cond_fall | cond_rise) begin
      pend_ok_d = 1'b0;
      cnt_d     = '0;
      busy_d    = cond_fall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      shift_q    <= '0;
      byte_q     <= '0;
      pend_val_q <= 1'b0;
      pend_ok_q  <= 1'b0;
      cond_q     <= '0;
      bit_q      <= 1'b0;
      bitv_q     <= 1'b0;
      bvld_q     <= 1'b0;
      ack_q      <= 1'b0;
      nack_q     <= 1'b0;
    end else begin
      scl_q      <= scl_i;
      sda_q      <= sda_i;
      busy_q     <= busy_d;
      cnt_q      <= cnt_d;
      shift_q    <= shift_d;
      byte_q     <= byte_d;
      pend_val_q <= pend_val_d;
      pend_ok_q  <= pend_ok_d;
      cond_q     <= cond_d;
      bit_q      <= bit_d;
      bitv_q     <= bitv_d;
      bvld_q     <= bvld_d;
      ack_q      <= ack_d;
      nack_q     <= nack_d;
    end
  end

  assign cond_o     = cond_q;
  assign bit_o      = bit_q;
  assign bit_val_o  = bitv_q;
  assign byte_o     = byte_q;
  assign byte_vld_o = bvld_q;
  assign ack_o      = ack_q;
  assign nack_o     = nack_q;
  assign busy_o     = busy_q;

endmodule

// File: rtl/twb_cond_mon.sv
module twb_cond_mon #(
  parameter int unsigned WAIT_CYC  = 40,
  parameter int unsigned BYTE_BITS = twb_mon_pkg::TWB_BYTE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 start_o,
  output logic                 rstart_o,
  output logic                 stop_o,
  output logic                 bit_o,
  output logic                 bit_val_o,
  output logic [BYTE_BITS-1:0] byte_o,
  output logic                 byte_vld_o,
  output logic                 ack_o,
  output logic                 nack_o,
  output logic                 busy_o,
  output logic                 wait_o,
  output logic                 err_o
);
  import twb_mon_pkg::*;

  localparam int unsigned NUM_LINES = 2;

  logic [NUM_LINES-1:0] raw_lines;
  logic [NUM_LINES-1:0] clean_lines;
  twb_cond_t            cond;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_filt
    twb_line_filter #(.RST_VAL(1'b1)) i_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(raw_lines[g]),
      .line_o(clean_lines[g])
    );
  end

  twb_stretch_timer #(.WAIT_CYC(WAIT_CYC)) i_stretch (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (clean_lines[0]),
    .wait_o(wait_o)
  );

  twb_cond_tracker #(.BYTE_BITS(BYTE_BITS)) i_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (clean_lines[0]),
    .sda_i     (clean_lines[1]),
    .cond_o    (cond),
    .bit_o     (bit_o),
    .bit_val_o (bit_val_o),
    .byte_o    (byte_o),
    .byte_vld_o(byte_vld_o),
    .ack_o     (ack_o),
    .nack_o    (nack_o),
    .busy_o    (busy_o)
  );

  assign start_o  = cond.start;
  assign rstart_o = cond.rstart;
  assign stop_o   = cond.stop;
  assign err_o    = cond.err;

endmodule

// File: rtl/twb_cond_mon_chk.sv
module twb_cond_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic start_o,
  input logic rstart_o,
  input logic stop_o,
  input logic bit_o,
  input logic byte_vld_o,
  input logic ack_o,
  input logic nack_o,
  input logic busy_o,
  input logic err_o
);

  p_cond_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, rstart_o, stop_o}));

  p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  p_stop_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> !stop_o);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> busy_o);

  p_rstart_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_o |-> busy_o);

  p_stop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> !busy_o);

  p_byte_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o);

  p_ack_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && nack_o));

  p_err_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (start_o || rstart_o || stop_o));

  p_bit_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bit_o |-> busy_o);

endmodule

bind twb_cond_mon twb_cond_mon_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_o   (start_o),
  .rstart_o  (rstart_o),
  .stop_o    (stop_o),
  .bit_o     (bit_o),
  .byte_vld_o(byte_vld_o),
  .ack_o     (ack_o),
  .nack_o    (nack_o),
  .busy_o    (busy_o),
  .err_o     (err_o)
);

// File: tb/test_twb_cond_mon.sv
`timescale 1ns/1ps
module test_twb_cond_mon;

  localparam int Q = 10;

  logic clk, rst_n, scl, sda;
  logic start_o, rstart_o, stop_o, bit_o, bit_val_o, byte_vld_o;
  logic ack_o, nack_o, busy_o, wait_o, err_o;
  logic [7:0] byte_o;

  int n_chk, n_fail;
  int c_start, c_rstart, c_stop, c_bit, c_byte, c_ack, c_nack, c_err, c_wait;
  logic [7:0] last_byte, prev_byte;
  bit done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  twb_cond_mon i_twb_cond_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .start_o(start_o), .rstart_o(rstart_o), .stop_o(stop_o),
    .bit_o(bit_o), .bit_val_o(bit_val_o), .byte_o(byte_o),
    .byte_vld_o(byte_vld_o), .ack_o(ack_o), .nack_o(nack_o),
    .busy_o(busy_o), .wait_o(wait_o), .err_o(err_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      c_start  += int'(start_o);
      c_rstart += int'(rstart_o);
      c_stop   += int'(stop_o);
      c_bit    += int'(bit_o);
      c_ack    += int'(ack_o);
      c_nack   += int'(nack_o);
      c_err    += int'(err_o);
      c_wait   += int'(wait_o);
      if (byte_vld_o) begin
        c_byte   += 1;
        prev_byte = last_byte;
        last_byte = byte_o;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda = 1'b1; scl = 1'b1; tick(Q);
    sda = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    sda = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_bit(input logic b);
    sda = b; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_byte(input logic [7:0] v, input logic nak);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    bus_bit(nak);
  endtask

  task automatic bus_stop();
    sda = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda = 1'b1; tick(2*Q);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(20);
    check("R1 busy after reset", int'(busy_o), 0);
    check("R1 wait after reset", int'(wait_o), 0);
    check("R1 strobes while idle", c_start + c_stop + c_bit + c_err, 0);
  endtask

  task automatic t_glitch();
    int s0, p0;
    s0 = c_start; p0 = c_stop;
    sda = 1'b0; tick(1); sda = 1'b1; tick(20);
    scl = 1'b0; tick(1); scl = 1'b1; tick(20);
    check("R9 sda spike no start", c_start - s0, 0);
    check("R9 spikes no stop", c_stop - p0, 0);
    check("R9 busy unchanged", int'(busy_o), 0);
  endtask

  task automatic t_idle_clocks();
    int b0;
    b0 = c_bit;
    for (int i = 0; i < 4; i++) begin
      scl = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    end
    tick(10);
    check("R11 no bits while idle", c_bit - b0, 0);
  endtask

  task automatic t_byte();
    int s0, p0, b0, y0, a0, n0, e0, w0;
    s0 = c_start; p0 = c_stop; b0 = c_bit; y0 = c_byte;
    a0 = c_ack; n0 = c_nack; e0 = c_err; w0 = c_wait;
    bus_start();
    check("R2 start strobe", c_start - s0, 1);
    check("R2 busy set", int'(busy_o), 1);
    bus_byte(8'hA5, 1'b0);
    check("R5 byte valid count", c_byte - y0, 1);
    check("R5 byte value MSB first", int'(last_byte), 'hA5);
    check("R5 bits committed", c_bit - b0, 9);
    check("R6 ack strobe", c_ack - a0, 1);
    check("R6 no nack", c_nack - n0, 0);
    check("R11 no condition from sda moves", c_start - s0, 1);
    bus_stop();
    check("R4 stop strobe", c_stop - p0, 1);
    check("R4 busy cleared", int'(busy_o), 0);
    check("R8 no error at boundary", c_err - e0, 0);
    check("R7 no wait on normal low", c_wait - w0, 0);
  endtask

  task automatic t_two_bytes();
    int y0, a0, n0;
    y0 = c_byte; a0 = c_ack; n0 = c_nack;
    bus_start();
    bus_byte(8'h3C, 1'b0);
    bus_byte(8'hC3, 1'b1);
    bus_stop();
    check("R6 two bytes assembled", c_byte - y0, 2);
    check("R6 first byte fresh", int'(prev_byte), 'h3C);
    check("R6 second byte fresh", int'(last_byte), 'hC3);
    check("R6 one ack", c_ack - a0, 1);
    check("R6 one nack", c_nack - n0, 1);
    check("R5 byte held", int'(byte_o), 'hC3);
  endtask

  task automatic t_rstart();
    int s0, r0, p0, e0;
    s0 = c_start; r0 = c_rstart; p0 = c_stop; e0 = c_err;
    bus_start();
    bus_byte(8'h5A, 1'b0);
    bus_rstart();
    check("R3 rstart strobe", c_rstart - r0, 1);
    check("R3 not a fresh start", c_start - s0, 1);
    check("R3 busy kept", int'(busy_o), 1);
    bus_byte(8'h81, 1'b1);
    check("R3 byte after rstart", int'(last_byte), 'h81);
    bus_stop();
    check("R4 stop after rstart", c_stop - p0, 1);
    check("R8 no error on rstart at boundary", c_err - e0, 0);
  endtask

  task automatic t_wait();
    int w0;
    w0 = c_wait;
    bus_start();
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b0);
    sda = 1'b1;
    tick(100);
    check("R7 wait during stretch", int'(wait_o), 1);
    scl = 1'b1; tick(10);
    check("R7 wait released on rise", int'(wait_o), 0);
    tick(2*Q - 10);
    scl = 1'b0; tick(Q);
    bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b0);
    bus_bit(1'b0);
    bus_stop();
    check("R7 byte through stretch", int'(last_byte), 'h96);
    check("R7 wait was seen", int'(c_wait - w0 > 0), 1);
  endtask

  task automatic t_err();
    int p0, e0;
    p0 = c_stop; e0 = c_err;
    bus_start();
    bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b0);
    bus_stop();
    check("R8 stop strobe mid byte", c_stop - p0, 1);
    check("R8 error strobe mid byte", c_err - e0, 1);
    check("R8 busy cleared", int'(busy_o), 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    c_start = 0; c_rstart = 0; c_stop = 0; c_bit = 0; c_byte = 0;
    c_ack = 0; c_nack = 0; c_err = 0; c_wait = 0;
    last_byte = '0; prev_byte = '0;
    t_reset();
    t_glitch();
    t_idle_clocks();
    t_byte();
    t_two_bytes();
    t_rstart();
    t_wait();
    t_err();
    check("R10 start count total", c_start, 5);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule